// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block sequences the reset and the two low-power modes of an 8-bit microcontroller core. It runs on the oscillator clock. It synchronises the external reset pin and samples it once per machine cycle. After enough consecutive high samples it raises the internal reset. It then drops that reset on a machine-cycle boundary. The block also supplies the reset values that the port latches, the stack pointer and the data pointer load while the internal reset is active.

The core asks for a low-power mode with one-cycle write strobes. The light-sleep strobe stops only the CPU clock enable; timers, serial logic and interrupt logic keep running. Any enabled pending interrupt, or the reset pin, wakes the core from light sleep. The deep-sleep strobe stops the oscillator and every clock enable. Only the reset pin can end deep sleep. A reset pulse that is too short returns the block to deep sleep. During either mode the block also forces the levels of the address-latch strobe and the program-fetch strobe. When code runs from external memory, it also asks for the low address/data port to float.

A separate active-low supply-good input clears the controller's own state at power-up.

Top module: `pmc_ctl`

## Requirements
- R1: The reset pin passes through a two-stage synchroniser. The synchronised value is sampled exactly once per machine cycle of `TICKS_PER_MC` (default 12) oscillator clocks, and only while the oscillator runs.
- R2: `int_rst` rises only after `RST_HOLD_MC` (default 2) consecutive samples find the pin high. A pin pulse that spans a single sample leaves `int_rst` low.
- R3: `int_rst` falls at the first machine-cycle boundary after a sample finds the pin low. Its rise and its fall therefore lie a whole number of machine cycles apart.
- R4: The reset-value outputs are fixed: `rv_port` = 8'hFF, `rv_sp` = 8'h07, `rv_dptr` = 16'h0000.
- R5: A light-sleep write (`idl_wr`) in the run mode gives `cpu_ce`=0, `per_ce`=1, `osc_run`=1 on the next clock.
- R6: A deep-sleep write (`pd_wr`) in the run mode gives `cpu_ce`=0, `per_ce`=0, `osc_run`=0 on the next clock, and the machine-cycle counter freezes. When both strobes arrive together, deep sleep wins.
- R7: Light sleep ends, back to the run mode (`cpu_ce`=1), one clock after `irq_pend` is high. It also ends three clocks after the reset pin rises, without waiting for a sample and before `int_rst` rises.
- R8: In deep sleep `irq_pend` has no effect. A high synchronised reset pin enters a wake state (`osc_run`=1, `cpu_ce`=0, `per_ce`=0). The wake state moves to the run mode once `int_rst` rises. It goes back to deep sleep if a sample finds the pin low first.
- R9: `pin_hold` is 1 outside the run mode. `pin_level` is 1 in light sleep and 0 in deep sleep and the wake state. `p0_float` equals `pin_hold` AND `code_ext`.
- R10: Both mode strobes are ignored while `int_rst` is high, and `pd_wr` is ignored during light sleep.
- R11: While `por_n` is low the block is in the run mode with `int_rst` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| por_n | input | 1 | Supply-good clear of the controller state, active low |
| rst_pin | input | 1 | External reset pin, asynchronous, active high |
| idl_wr | input | 1 | One-cycle strobe: enter light sleep |
| pd_wr | input | 1 | One-cycle strobe: enter deep sleep |
| irq_pend | input | 1 | An enabled interrupt is pending |
| code_ext | input | 1 | Core executes from external program memory |
| cpu_ce | output | 1 | CPU clock enable |
| per_ce | output | 1 | Timer, serial and interrupt clock enable |
| osc_run | output | 1 | Oscillator run enable |
| int_rst | output | 1 | Internal reset, active high |
| pin_hold | output | 1 | Force the address-latch and fetch strobes |
| pin_level | output | 1 | Level forced on those strobes |
| p0_float | output | 1 | Release the low address/data port |
| rv_port | output | 8 | Reset value for the port latches |
| rv_sp | output | 8 | Reset value for the stack pointer |
| rv_dptr | output | 16 | Reset value for the data pointer |

## Verification
The assertions assume that `idl_wr` and `pd_wr` are one-clock strobes. They also assume that `por_n` is low from time zero until the clock has run a few edges, so that every `$past` refers to cleared state. The bench drives each strobe for one clock at a falling edge. It drives the reset pin only in whole clocks, in pulses chosen to cover either one sample or at least two. It raises `irq_pend` only as a single-cycle pulse, so a pending interrupt never overlaps a mode write.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        M_RUN   = 2'd0,
        M_IDLE  = 2'd1,
        M_PDOWN = 2'd2,
        M_WAKE  = 2'd3
    } pmode_e;

    localparam logic [7:0]  PORT_RST_VAL = 8'hFF;
    localparam logic [7:0]  SP_RST_VAL   = 8'h07;
    localparam logic [15:0] DPTR_RST_VAL = 16'h0000;

endpackage

// File: rtl/pmc_cycle_timer.sv
module pmc_cycle_timer #(
    parameter int TICKS_PER_MC = 12,
    parameter int RST_HOLD_MC  = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin,
    input  logic run,
    output logic rst_s,
    output logic sample,
    output logic int_rst
);

    localparam int TW = (TICKS_PER_MC > 1) ? $clog2(TICKS_PER_MC) : 1;
    localparam int HW = $clog2(RST_HOLD_MC + 1);
    localparam logic [TW-1:0] LAST_TICK = TW'(TICKS_PER_MC - 1);
    localparam logic [HW-1:0] HOLD_V    = HW'(RST_HOLD_MC);
    localparam logic [HW-1:0] HOLD_M1   = HW'(RST_HOLD_MC - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [TW-1:0]          tick;
        logic [HW-1:0]          hi;
        logic                   irst;
    } tmr_t;

    tmr_t q, d;

    assign rst_s   = q.sync[SYNC_STAGES-1];
    assign sample  = run && (q.tick == LAST_TICK);
    assign int_rst = q.irst;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], rst_pin};
        if (run) begin
            d.tick = (q.tick == LAST_TICK) ? '0 : q.tick + TW'(1);
        end
        if (sample) begin
            if (rst_s) begin
                d.hi = (q.hi == HOLD_V) ? q.hi : q.hi + HW'(1);
                if (q.hi >= HOLD_M1) begin
                    d.irst = 1'b1;
                end
            end else begin
                d.hi   = '0;
                d.irst = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q <= '{sync: '0, tick: '0, hi: '0, irst: 1'b1};
        end else begin
            q <= d;
        end
    end

    // R2: a rise of the internal reset follows a sample that saw the pin high
    a_r2_rise_after_high_sample: assert property (@(posedge clk) disable iff (!por_n)
        $rose(q.irst) |-> $past(rst_s && sample));

    // R3: release lands on a machine-cycle boundary after a low sample
    a_r3_release_on_boundary: assert property (@(posedge clk) disable iff (!por_n)
        $fell(q.irst) |-> (q.tick == '0) && $past(!rst_s));

    // R6: the machine-cycle counter holds while the oscillator is stopped
    a_r6_tick_frozen: assert property (@(posedge clk) disable iff (!por_n)
        $past(!run) |-> $stable(q.tick));

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic rst_s,
    input  logic sample,
    input  logic int_rst,
    input  logic idl_wr,
    input  logic pd_wr,
    input  logic irq_pend,
    input  logic code_ext,
    output logic cpu_ce,
    output logic per_ce,
    output logic osc_run,
    output logic pin_hold,
    output logic pin_level,
    output logic p0_float
);

    typedef struct packed {
        pmode_e mode;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d = q;
        unique case (q.mode)
            M_RUN: begin
                if (!int_rst) begin
                    if (pd_wr) begin
                        d.mode = M_PDOWN;
                    end else if (idl_wr) begin
                        d.mode = M_IDLE;
                    end
                end
            end
            M_IDLE: begin
                if (rst_s || irq_pend) begin
                    d.mode = M_RUN;
                end
            end
            M_PDOWN: begin
                if (rst_s) begin
                    d.mode = M_WAKE;
                end
            end
            M_WAKE: begin
                if (int_rst) begin
                    d.mode = M_RUN;
                end else if (sample && !rst_s) begin
                    d.mode = M_PDOWN;
                end
            end
            default: d.mode = M_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q <= '{mode: M_RUN};
        end else begin
            q <= d;
        end
    end

    assign osc_run   = (q.mode != M_PDOWN);
    assign cpu_ce    = (q.mode == M_RUN);
    assign per_ce    = (q.mode == M_RUN) || (q.mode == M_IDLE);
    assign pin_hold  = (q.mode != M_RUN);
    assign pin_level = (q.mode == M_IDLE);
    assign p0_float  = pin_hold && code_ext;

    // R8: deep sleep is left only when the synchronised pin was high
    a_r8_pd_exit_by_pin: assert property (@(posedge clk) disable iff (!por_n)
        ($past(q.mode == M_PDOWN) && (q.mode != M_PDOWN)) |-> $past(rst_s));

    // R8: the wake state reaches the run mode only through the internal reset
    a_r8_wake_needs_reset: assert property (@(posedge clk) disable iff (!por_n)
        ($past(q.mode == M_WAKE) && (q.mode == M_RUN)) |-> $past(int_rst));

    // R7: light sleep ends only on an interrupt or the pin
    a_r7_idle_exit_cause: assert property (@(posedge clk) disable iff (!por_n)
        ($past(q.mode == M_IDLE) && (q.mode != M_IDLE)) |-> $past(irq_pend || rst_s));

    // R10: mode strobes have no effect while the internal reset is high
    a_r10_writes_masked: assert property (@(posedge clk) disable iff (!por_n)
        $past(int_rst && (q.mode == M_RUN)) |-> (q.mode == M_RUN));

    // R6: a deep-sleep write from the run mode wins over light sleep
    a_r6_pd_priority: assert property (@(posedge clk) disable iff (!por_n)
        $past((q.mode == M_RUN) && !int_rst && pd_wr) |-> (q.mode == M_PDOWN));

endmodule

// File: rtl/pmc_ctl.sv
module pmc_ctl
    import pmc_pkg::*;
#(
    parameter int TICKS_PER_MC = 12,
    parameter int RST_HOLD_MC  = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 16
) (
    input  logic              clk_osc,
    input  logic              por_n,
    input  logic              rst_pin,
    input  logic              idl_wr,
    input  logic              pd_wr,
    input  logic              irq_pend,
    input  logic              code_ext,
    output logic              cpu_ce,
    output logic              per_ce,
    output logic              osc_run,
    output logic              int_rst,
    output logic              pin_hold,
    output logic              pin_level,
    output logic              p0_float,
    output logic [DATA_W-1:0] rv_port,
    output logic [DATA_W-1:0] rv_sp,
    output logic [ADDR_W-1:0] rv_dptr
);

    logic rst_s;
    logic sample;

    pmc_cycle_timer #(
        .TICKS_PER_MC (TICKS_PER_MC),
        .RST_HOLD_MC  (RST_HOLD_MC),
        .SYNC_STAGES  (SYNC_STAGES)
    ) u_timer (
        .clk     (clk_osc),
        .por_n   (por_n),
        .rst_pin (rst_pin),
        .run     (osc_run),
        .rst_s   (rst_s),
        .sample  (sample),
        .int_rst (int_rst)
    );

    pmc_mode_fsm u_fsm (
        .clk       (clk_osc),
        .por_n     (por_n),
        .rst_s     (rst_s),
        .sample    (sample),
        .int_rst   (int_rst),
        .idl_wr    (idl_wr),
        .pd_wr     (pd_wr),
        .irq_pend  (irq_pend),
        .code_ext  (code_ext),
        .cpu_ce    (cpu_ce),
        .per_ce    (per_ce),
        .osc_run   (osc_run),
        .pin_hold  (pin_hold),
        .pin_level (pin_level),
        .p0_float  (p0_float)
    );

    assign rv_port = DATA_W'(PORT_RST_VAL);
    assign rv_sp   = DATA_W'(SP_RST_VAL);
    assign rv_dptr = ADDR_W'(DPTR_RST_VAL);

    // R9: outside light sleep the forced strobe level is never high
    a_r9_level_only_idle: assert property (@(posedge clk_osc) disable iff (!por_n)
        (pin_level |-> (per_ce && !cpu_ce)));

endmodule

// File: tb/pmc_ctl_bench.sv
module pmc_ctl_bench;

    logic clk_osc = 1'b0;
    logic por_n, rst_pin, idl_wr, pd_wr, irq_pend, code_ext;
    logic cpu_ce, per_ce, osc_run, int_rst, pin_hold, pin_level, p0_float;
    logic [7:0]  rv_port, rv_sp;
    logic [15:0] rv_dptr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk_osc = ~clk_osc;

    pmc_ctl u_pmc_ctl (
        .clk_osc(clk_osc), .por_n(por_n), .rst_pin(rst_pin), .idl_wr(idl_wr),
        .pd_wr(pd_wr), .irq_pend(irq_pend), .code_ext(code_ext),
        .cpu_ce(cpu_ce), .per_ce(per_ce), .osc_run(osc_run), .int_rst(int_rst),
        .pin_hold(pin_hold), .pin_level(pin_level), .p0_float(p0_float),
        .rv_port(rv_port), .rv_sp(rv_sp), .rv_dptr(rv_dptr)
    );

    // stimulus {idl, pd, irq, ext} ; expected {cpu, per, osc, hold, lvl, p0f}
    localparam logic [9:0] VEC [6] = '{
        10'b1001_011111,  // R5 R9: enter light sleep, port floats
        10'b0100_011110,  // R10: deep-sleep write ignored in light sleep
        10'b0010_111000,  // R7: interrupt wakes
        10'b0011_111000,  // R7: interrupt in run mode changes nothing
        10'b1101_000101,  // R6 R9: both strobes, deep sleep wins
        10'b0010_000100   // R8: interrupt ignored in deep sleep
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_osc);
    endtask

    task automatic wait_release(output int steps);
        steps = 0;
        for (int i = 0; i < 40; i++) begin
            if (!int_rst) break;
            @(negedge clk_osc);
            steps++;
        end
    endtask

    task automatic pulse(input bit idl, input bit pd, input bit irq);
        idl_wr = idl; pd_wr = pd; irq_pend = irq;
        step(1);
        idl_wr = 1'b0; pd_wr = 1'b0; irq_pend = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk_osc);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int g;
        int r;
        bit seen;
        por_n = 1'b0; rst_pin = 1'b1; idl_wr = 1'b0; pd_wr = 1'b0;
        irq_pend = 1'b0; code_ext = 1'b0;
        step(3);
        chk(int_rst == 1'b1, "R11 int_rst during clear", int_rst, 1);
        chk(cpu_ce == 1'b1 && osc_run == 1'b1, "R11 run mode during clear", {cpu_ce, osc_run}, 3);
        chk(rv_port == 8'hFF, "R4 port value", rv_port, 8'hFF);
        chk(rv_sp == 8'h07, "R4 stack value", rv_sp, 8'h07);
        chk(rv_dptr == 16'h0000, "R4 dptr value", rv_dptr, 0);

        por_n = 1'b1;
        step(40);
        chk(int_rst == 1'b1, "R2 held while pin high", int_rst, 1);
        rst_pin = 1'b0;
        wait_release(g);
        chk(int_rst == 1'b0 && g <= 16, "R3 release after pin low", g, 16);

        // single-sample pulse: exactly 12 clocks high
        step(5);
        rst_pin = 1'b1; step(12); rst_pin = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 30; i++) begin
            step(1);
            if (int_rst) seen = 1'b1;
        end
        chk(!seen, "R2 one-sample pulse ignored", seen, 0);
        chk(cpu_ce == 1'b1, "R1 still running after short pulse", cpu_ce, 1);

        // long pulse: rise and fall spacing
        rst_pin = 1'b1;
        r = 0;
        for (int i = 0; i < 40; i++) begin
            step(1);
            r++;
            if (int_rst) break;
        end
        chk(int_rst == 1'b1, "R2 long pulse asserts", int_rst, 1);
        step(5);
        rst_pin = 1'b0;
        wait_release(g);
        chk(((5 + g) % 12) == 0, "R3 rise-to-fall whole machine cycles", 5 + g, 12);

        // table walk
        step(3);
        foreach (VEC[k]) begin
            logic [5:0] exp;
            exp = VEC[k][5:0];
            code_ext = VEC[k][6];
            pulse(VEC[k][9], VEC[k][8], VEC[k][7]);
            chk({cpu_ce, per_ce, osc_run, pin_hold, pin_level, p0_float} == exp,
                $sformatf("R5 R6 R7 R8 R9 R10 vector %0d", k),
                {cpu_ce, per_ce, osc_run, pin_hold, pin_level, p0_float}, exp);
        end
        code_ext = 1'b0;

        // short pin pulse from deep sleep
        step(10);
        chk(osc_run == 1'b0, "R6 oscillator stays stopped", osc_run, 0);
        rst_pin = 1'b1;
        step(2);
        chk(osc_run == 1'b0, "R8 wake waits for synchroniser", osc_run, 0);
        step(1);
        chk({osc_run, cpu_ce, per_ce, pin_hold, pin_level} == 5'b10010,
            "R8 R9 wake state", {osc_run, cpu_ce, per_ce, pin_hold, pin_level}, 5'b10010);
        step(3);
        rst_pin = 1'b0;
        step(40);
        chk(osc_run == 1'b0 && int_rst == 1'b0, "R8 short pulse back to deep sleep",
            {osc_run, int_rst}, 0);

        // long pin from deep sleep
        rst_pin = 1'b1;
        step(40);
        chk(int_rst == 1'b1 && cpu_ce == 1'b1, "R8 reset leaves deep sleep",
            {int_rst, cpu_ce}, 3);

        // strobes during internal reset
        pulse(1'b1, 1'b0, 1'b0);
        step(1);
        chk(cpu_ce == 1'b1, "R10 idle write masked in reset", cpu_ce, 1);
        pulse(1'b0, 1'b1, 1'b0);
        step(1);
        chk(osc_run == 1'b1 && cpu_ce == 1'b1, "R10 pd write masked in reset",
            {osc_run, cpu_ce}, 3);
        rst_pin = 1'b0;
        wait_release(g);
        chk(int_rst == 1'b0, "R3 release after deep-sleep reset", int_rst, 0);

        // pin ends light sleep before the internal reset
        step(2);
        pulse(1'b1, 1'b0, 1'b0);
        chk(cpu_ce == 1'b0 && per_ce == 1'b1, "R5 light sleep again", {cpu_ce, per_ce}, 1);
        rst_pin = 1'b1;
        step(2);
        chk(cpu_ce == 1'b0, "R7 pin wake after synchroniser", cpu_ce, 0);
        step(1);
        chk(cpu_ce == 1'b1 && int_rst == 1'b0, "R7 pin wakes before reset",
            {cpu_ce, int_rst}, 2);
        rst_pin = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 30; i++) begin
            step(1);
            if (int_rst) seen = 1'b1;
        end
        chk(!seen && cpu_ce == 1'b1, "R2 brief pin causes no reset", {seen, cpu_ce}, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule